// File: doc/BRIEF.md
# Sector Group Protection Logic

This block decides, for every program or erase request, whether the addressed sector may be altered. It holds one protect bit for each group of four adjacent sectors. The command decoder sets these bits one group at a time and can clear all of them in a single operation. The permit result comes from the stored bits and three override inputs, and is produced combinationally from the requested sector address.

The overrides are as follows. An active-low write-protect pin always locks one fixed boundary sector. A temporary-unprotect level and an accelerate level each lift all stored protection while they are held. When either level is removed, the stored protection applies again unchanged. A separate verify port returns a status byte that reports the stored protection of any sector.

The protect bits model non-volatile cells. For that reason the ordinary reset leaves them untouched, and only a dedicated initialisation input clears them.

Top module: `sector_guard`

## Requirements
- R1: A sector address is 7 bits wide (128 sectors). Its group is bits [6:2] of the address, so the four sectors of a group always share one protect bit.
- R2: A cycle with `prot_set_i` high sets the bit of the group that contains `prot_sector_i`, where `prot_sector_i` may be any sector of that group. The new value applies from the next cycle. No other group bit changes.
- R3: A cycle with `unprot_all_i` high clears every group bit from the next cycle. It takes priority over a `prot_set_i` in the same cycle.
- R4: `init_i` clears every group bit from the next cycle. `rst_ni` does not change any group bit.
- R5: With `wp_ni` high and both override levels low, `permit_o` is high exactly when the group of `req_sector_i` is unprotected. The result is valid in the same cycle as the request.
- R6: With `wp_ni` low, the boundary sector is always denied (`permit_o` low), whatever its group bit and the override levels say. The boundary sector is sector 0 when `BOOT_TOP` is 1 and sector 127 when it is 0.
- R7: With `wp_ni` high, the boundary sector follows its stored group bit like any other sector.
- R8: While `tmp_unprot_i` is high, every sector except a sector denied by R6 is permitted. After the level drops, the stored bits apply again unchanged.
- R9: `accel_i` high has the same effect as `tmp_unprot_i` high, as described in R8.
- R10: A cycle with `vfy_rd_i` high makes `vfy_data_o` equal 01h in the next cycle if the group of `vfy_sector_i` is stored as protected, and 00h if it is not. The override inputs do not affect this value. `vfy_data_o` holds its value until the next read, and it is 00h while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (verify register only) |
| init_i | input | 1 | Clears all protect bits |
| prot_set_i | input | 1 | Group-protect command strobe |
| prot_sector_i | input | 7 | Any sector inside the group to protect |
| unprot_all_i | input | 1 | Chip-wide unprotect strobe |
| wp_ni | input | 1 | Write-protect, active low, locks the boundary sector |
| tmp_unprot_i | input | 1 | Temporary unprotect level |
| accel_i | input | 1 | Accelerate level, also unprotects |
| req_sector_i | input | 7 | Sector of a program/erase request |
| permit_o | output | 1 | Request may proceed |
| vfy_rd_i | input | 1 | Protection verify read strobe |
| vfy_sector_i | input | 7 | Sector to verify |
| vfy_data_o | output | 8 | Verify status byte |

## Verification
The assertions check on every cycle several fixed relations. The boundary sector is never permitted while write-protect is low. Either override level permits every sector that is not the boundary case. The bits update only in response to a strobe. The status byte never carries anything but bit 0. The bench's scenarios are needed for the rest: that a protect named through any sector reaches the whole group, that the stored state survives a reset, and that protection returns intact after the override levels fall. Only the scenarios also show the verify byte following the stored bits rather than the overrides.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  typedef enum logic [7:0] {
    VFY_OPEN   = 8'h00,
    VFY_LOCKED = 8'h01
  } vfy_code_e;
endpackage

// File: rtl/sgp_bits.sv
module sgp_bits #(
  parameter int NUM_GRP = 32,
  parameter int GRP_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic               set_i,
  input  logic [GRP_W-1:0]   set_grp_i,
  input  logic               clr_all_i,
  output logic [NUM_GRP-1:0] bits_o
);
  logic [NUM_GRP-1:0] bits_q;

  // non-volatile model: no reset branch
  always_ff @(posedge clk_i) begin
    if (init_i || clr_all_i) bits_q <= '0;
    else if (set_i)          bits_q[set_grp_i] <= 1'b1;
  end

  assign bits_o = bits_q;

  // R2
  grp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !init_i && !clr_all_i |=> bits_q[$past(set_grp_i)]);
  // R3
  clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> bits_q == '0);
  // R4
  init_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> bits_q == '0);
  // R2
  bits_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !init_i && !clr_all_i |=> $stable(bits_q));
endmodule

// File: rtl/sgp_permit.sv
module sgp_permit #(
  parameter int SECT_W    = 7,
  parameter int GRP_SHIFT = 2,
  parameter int NUM_GRP   = 32,
  parameter bit BOOT_TOP  = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_GRP-1:0] bits_i,
  input  logic [SECT_W-1:0]  sector_i,
  input  logic               wp_ni,
  input  logic               tmp_unprot_i,
  input  logic               accel_i,
  output logic               permit_o
);
  localparam int GRP_W = SECT_W - GRP_SHIFT;

  logic             is_bound;
  logic [GRP_W-1:0] grp;
  logic             lifted;

  generate
    if (BOOT_TOP) begin : g_bound_low
      assign is_bound = (sector_i == '0);
    end else begin : g_bound_high
      assign is_bound = (sector_i == {SECT_W{1'b1}});
    end
  endgenerate

  assign grp    = sector_i[SECT_W-1:GRP_SHIFT];
  assign lifted = tmp_unprot_i | accel_i;

  always_comb begin
    if (is_bound && !wp_ni) permit_o = 1'b0;
    else if (lifted)        permit_o = 1'b1;
    else                    permit_o = ~bits_i[grp];
  end

  // R6
  wp_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_bound && !wp_ni |-> !permit_o);
  // R8
  tmp_lift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmp_unprot_i && !(is_bound && !wp_ni) |-> permit_o);
  // R9
  acc_lift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accel_i && !(is_bound && !wp_ni) |-> permit_o);
endmodule

// File: rtl/sgp_verify.sv
module sgp_verify
  import sgp_pkg::*;
#(
  parameter int SECT_W    = 7,
  parameter int GRP_SHIFT = 2,
  parameter int NUM_GRP   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_GRP-1:0] bits_i,
  input  logic               rd_i,
  input  logic [SECT_W-1:0]  sector_i,
  output logic [7:0]         data_o
);
  vfy_code_e code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= VFY_OPEN;
    else if (rd_i)
      code_q <= bits_i[sector_i[SECT_W-1:GRP_SHIFT]] ? VFY_LOCKED : VFY_OPEN;
  end

  assign data_o = code_q;

  // R10
  vfy_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o[7:1] == '0);
  // R10
  vfy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(data_o));
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int SECT_W    = 7,
  parameter int GRP_SHIFT = 2,
  parameter bit BOOT_TOP  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              prot_set_i,
  input  logic [SECT_W-1:0] prot_sector_i,
  input  logic              unprot_all_i,
  input  logic              wp_ni,
  input  logic              tmp_unprot_i,
  input  logic              accel_i,
  input  logic [SECT_W-1:0] req_sector_i,
  output logic              permit_o,
  input  logic              vfy_rd_i,
  input  logic [SECT_W-1:0] vfy_sector_i,
  output logic [7:0]        vfy_data_o
);
  localparam int GRP_W   = SECT_W - GRP_SHIFT;
  localparam int NUM_GRP = 1 << GRP_W;

  logic [NUM_GRP-1:0] bits;

  sgp_bits #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) i_bits (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (init_i),
    .set_i     (prot_set_i),
    .set_grp_i (prot_sector_i[SECT_W-1:GRP_SHIFT]),
    .clr_all_i (unprot_all_i),
    .bits_o    (bits)
  );

  sgp_permit #(.SECT_W(SECT_W), .GRP_SHIFT(GRP_SHIFT), .NUM_GRP(NUM_GRP),
               .BOOT_TOP(BOOT_TOP)) i_permit (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bits_i       (bits),
    .sector_i     (req_sector_i),
    .wp_ni        (wp_ni),
    .tmp_unprot_i (tmp_unprot_i),
    .accel_i      (accel_i),
    .permit_o     (permit_o)
  );

  sgp_verify #(.SECT_W(SECT_W), .GRP_SHIFT(GRP_SHIFT), .NUM_GRP(NUM_GRP)) i_verify (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bits_i   (bits),
    .rd_i     (vfy_rd_i),
    .sector_i (vfy_sector_i),
    .data_o   (vfy_data_o)
  );
endmodule

// File: tb/test_sector_guard.sv
module test_sector_guard;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       init_i = 1'b0;
  logic       prot_set_i = 1'b0;
  logic [6:0] prot_sector_i = '0;
  logic       unprot_all_i = 1'b0;
  logic       wp_ni = 1'b1;
  logic       tmp_unprot_i = 1'b0;
  logic       accel_i = 1'b0;
  logic [6:0] req_sector_i = '0;
  logic       permit_o;
  logic       vfy_rd_i = 1'b0;
  logic [6:0] vfy_sector_i = '0;
  logic [7:0] vfy_data_o;

  int errors = 0;
  int checks = 0;
  bit model_valid = 0;
  bit model_bits [32];
  int exp_vfy = 0;

  always #4 clk_i = ~clk_i;

  sector_guard i_sector_guard (
    .clk_i, .rst_ni, .init_i, .prot_set_i, .prot_sector_i, .unprot_all_i,
    .wp_ni, .tmp_unprot_i, .accel_i, .req_sector_i, .permit_o,
    .vfy_rd_i, .vfy_sector_i, .vfy_data_o
  );

  function automatic bit exp_permit(int sec);
    if (sec == 0 && !wp_ni) return 1'b0;
    if (tmp_unprot_i || accel_i) return 1'b1;
    return !model_bits[sec / 4];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // called right after inputs change at a falling edge
  task automatic tick(string req);
    #1;
    if (model_valid)
      check(permit_o == exp_permit(int'(req_sector_i)), req, permit_o,
            exp_permit(int'(req_sector_i)));
    @(posedge clk_i);
    if (!rst_ni) exp_vfy = 0;
    else if (vfy_rd_i) exp_vfy = model_bits[int'(vfy_sector_i) / 4] ? 1 : 0;
    if (init_i || unprot_all_i) begin
      foreach (model_bits[g]) model_bits[g] = 1'b0;
      model_valid = 1;
    end else if (prot_set_i) model_bits[int'(prot_sector_i) / 4] = 1'b1;
    @(negedge clk_i);
    check(vfy_data_o == 8'(exp_vfy), req, vfy_data_o, exp_vfy);
    prot_set_i = 0; unprot_all_i = 0; init_i = 0; vfy_rd_i = 0;
  endtask

  task automatic sweep(string req);
    for (int s = 0; s < 128; s += 3) begin
      req_sector_i = 7'(s);
      tick(req);
    end
  endtask

  task automatic verify(int s, string req);
    vfy_rd_i = 1; vfy_sector_i = 7'(s);
    tick(req);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    tick("R10_reset");
    check(vfy_data_o == 8'h00, "R10_reset", vfy_data_o, 0);
    rst_ni = 1;
    init_i = 1;
    tick("R4_init");
    sweep("R5_all_open");
    // R2: protect via last sector of group 3 and first of group 20
    prot_set_i = 1; prot_sector_i = 7'd15; tick("R2");
    prot_set_i = 1; prot_sector_i = 7'd80; tick("R2");
    for (int s = 12; s < 16; s++) begin req_sector_i = 7'(s); tick("R1_group"); end
    req_sector_i = 7'd16; tick("R2_neighbour");
    sweep("R5_mixed");
    verify(13, "R10_locked");
    verify(17, "R10_open");
    verify(83, "R10_locked");
    // R6/R7 boundary sector 0
    req_sector_i = 7'd0; tick("R7_open");
    wp_ni = 0; tick("R6_wp");
    tmp_unprot_i = 1; tick("R6_over_tmp");
    tmp_unprot_i = 0; accel_i = 1; tick("R6_over_acc");
    accel_i = 0; req_sector_i = 7'd1; tick("R6_other_sector");
    wp_ni = 1;
    prot_set_i = 1; prot_sector_i = 7'd2; tick("R2_bound_grp");
    req_sector_i = 7'd0; tick("R7_locked");
    // R8/R9
    tmp_unprot_i = 1; sweep("R8_tmp");
    verify(13, "R10_ignores_tmp");
    tmp_unprot_i = 0; sweep("R8_restore");
    accel_i = 1; sweep("R9_acc");
    accel_i = 0; sweep("R9_restore");
    // R4: reset keeps bits
    rst_ni = 0; tick("R4_rst"); tick("R4_rst");
    rst_ni = 1;
    verify(14, "R4_rst_keeps");
    sweep("R4_rst_keeps");
    // R3: chip unprotect beats protect in same cycle
    unprot_all_i = 1; prot_set_i = 1; prot_sector_i = 7'd40; tick("R3");
    sweep("R3_cleared");
    verify(40, "R3_cleared");
    verify(13, "R3_cleared");
    // R4: init after protection
    prot_set_i = 1; prot_sector_i = 7'd127; tick("R2_top");
    verify(124, "R2_top");
    init_i = 1; tick("R4_init2");
    verify(127, "R4_init2");
    sweep("R4_init2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule